// File: doc/BRIEF.md
# Transmit Tap Coefficient Search Engine

This block drives the receive side of link training. Once auto-negotiation reports completion, it steers one transmit equalizer tap of the link partner with increment and decrement requests. First it walks the tap down to its minimum. Then it climbs one step at a time. At each setting it counts bit errors seen on the received training pattern over a programmable window. It records the lowest and highest settings of the first contiguous run of settings whose error count stays within a programmable threshold.

When the run ends, the engine steps the tap back down to the truncated midpoint of that run and raises a done flag, which gates the high-speed data path. A run ends at a failing setting, or when the partner reports that the tap is at its maximum. If no setting passes, a fail flag is raised instead. A manual mode parks the automatic sequencer and passes a software-written request code straight to the partner.

Top module: `tap_search_engine`

## Requirements
- R1: While `anDone` is low and manual mode is off, `reqCode` is hold (00) from the next cycle on. Dropping `anDone` clears `trainDone` and `trainFail` and abandons any search in progress.
- R2: Request codes are 00 hold, 01 increment, 10 decrement. The automatic sequencer never issues 11.
- R3: Partner status codes are 00 not updated, 01 updated, 10 minimum, 11 maximum. A request is held unchanged until status becomes nonzero. It then returns to hold, and no new request is issued until status is back to 00.
- R4: A search first issues decrements until the partner answers minimum. No increment is issued before that; the minimum setting is the first one measured.
- R5: At each measured setting, error events are counted over `winLen` cycles (0 acts as 1). The setting passes when the count is at most `errThresh`.
- R6: The recorded region is the first contiguous run of passing settings found while climbing. It ends at the first failing setting after it, or at a setting whose increment was answered with maximum.
- R7: After the scan, the tap is stepped down by single decrements to floor((lower + upper) / 2).
- R8: `trainDone` rises when the tap is at the midpoint and then stays high, with `reqCode` at hold, until `anDone` falls or manual mode is entered.
- R9: If no setting passes, `trainFail` is raised instead of `trainDone`. The two flags are never high together.
- R10: With `manualMode` high, `reqCode` equals `swReq`, no automatic request is made, and neither flag rises. Clearing it with `anDone` high starts a fresh search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| anDone | input | 1 | Auto-negotiation complete; low aborts training |
| manualMode | input | 1 | Hands request generation to software |
| swReq | input | 2 | Software request code used in manual mode |
| partnerStatus | input | 2 | Partner status for the tap |
| errEvent | input | 1 | One bit error on the training pattern this cycle |
| winLen | input | WIN_W | Measurement window length in cycles |
| errThresh | input | ERR_W | Largest error count that still passes |
| reqCode | output | 2 | Request code to the partner |
| trainDone | output | 1 | Training finished, tap centered |
| trainFail | output | 1 | No passing setting found |

## Verification
The evaluation of a setting and the partner's maximum report can fall on the same step. The final increment is answered with maximum, and the window that follows at that setting comes out clean. The engine must then both record that setting as the upper edge and end the scan. A scenario with the clean region touching the top of the partner's tap range provokes this case. It is judged by the final tap position, which lies midway between the region's lower edge and the maximum. Threshold scenarios, where marginal settings give exactly the threshold or one more, check that boundary of the pass decision.

// File: rtl/tap_search_pkg.sv
package tap_search_pkg;

  localparam logic [1:0] REQ_HOLD = 2'b00;
  localparam logic [1:0] REQ_INC  = 2'b01;
  localparam logic [1:0] REQ_DEC  = 2'b10;

  localparam logic [1:0] STS_NONE = 2'b00;
  localparam logic [1:0] STS_UPD  = 2'b01;
  localparam logic [1:0] STS_MIN  = 2'b10;
  localparam logic [1:0] STS_MAX  = 2'b11;

  typedef struct packed {
    logic clrRegion;
    logic posClr;
    logic posInc;
    logic posDec;
    logic winClr;
    logic winRun;
    logic record;
    logic latchMax;
    logic maxVal;
  } ctl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SEEK_REQ, S_SEEK_REL, S_BASE_REL, S_MEASURE, S_EVAL,
    S_UP_REQ, S_UP_REL, S_CENTER, S_BACK_REQ, S_BACK_REL, S_DONE, S_FAIL
  } state_t;

endpackage

// File: rtl/tap_search_dp.sv
module tap_search_dp
  import tap_search_pkg::*;
#(
  parameter int POS_W = 6,
  parameter int WIN_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic             errEvent,
  input  logic [WIN_W-1:0] winLen,
  input  logic [ERR_W-1:0] errThresh,
  output logic             winLast,
  output logic             pass,
  output logic             found,
  output logic             atMax,
  output logic             atTarget
);

  localparam logic [POS_W-1:0] POS_TOP = {POS_W{1'b1}};
  localparam logic [ERR_W-1:0] ERR_TOP = {ERR_W{1'b1}};

  logic [POS_W-1:0] pos, lower, upper;
  logic             foundQ, maxQ;
  logic [WIN_W-1:0] winCnt;
  logic [ERR_W-1:0] errCnt;
  logic [POS_W:0]   midSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
      maxQ <= 1'b0;
    end else begin
      if (ctl.clrRegion || ctl.posClr) pos <= '0;
      else if (ctl.posInc) pos <= pos + 1'b1;
      else if (ctl.posDec) pos <= pos - 1'b1;
      if (ctl.clrRegion) maxQ <= 1'b0;
      else if (ctl.latchMax) maxQ <= ctl.maxVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lower <= '0;
      upper <= '0;
      foundQ <= 1'b0;
    end else if (ctl.clrRegion) begin
      lower <= '0;
      upper <= '0;
      foundQ <= 1'b0;
    end else if (ctl.record && pass) begin
      if (!foundQ) lower <= pos;
      upper <= pos;
      foundQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      errCnt <= '0;
    end else if (ctl.winClr) begin
      winCnt <= '0;
      errCnt <= '0;
    end else if (ctl.winRun) begin
      winCnt <= winCnt + 1'b1;
      if (errEvent && errCnt != ERR_TOP) errCnt <= errCnt + 1'b1;
    end
  end

  assign winLast  = ({1'b0, winCnt} + 1'b1) >= {1'b0, winLen};
  assign pass     = errCnt <= errThresh;
  assign found    = foundQ;
  assign atMax    = maxQ || (pos == POS_TOP);
  assign midSum   = {1'b0, lower} + {1'b0, upper};
  assign atTarget = pos == midSum[POS_W:1];

  // R6: a recorded region never has its upper edge below its lower edge
  assert_region_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    foundQ |-> lower <= upper);

  // R7: stepping back toward the midpoint never starts below it
  assert_center_from_above_R7: assert property (@(posedge clk) disable iff (!rstN)
    (foundQ && ctl.posDec) |-> pos > midSum[POS_W:1]);

endmodule

// File: rtl/tap_search_ctrl.sv
module tap_search_ctrl
  import tap_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anDone,
  input  logic       manualMode,
  input  logic [1:0] swReq,
  input  logic [1:0] partnerStatus,
  input  logic       winLast,
  input  logic       pass,
  input  logic       found,
  input  logic       atMax,
  input  logic       atTarget,
  output ctl_t       ctl,
  output logic [1:0] reqCode,
  output logic       trainDone,
  output logic       trainFail
);

  state_t state, nxt;
  logic [1:0] autoReq;
  logic acked, released;

  assign acked    = partnerStatus != STS_NONE;
  assign released = partnerStatus == STS_NONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else state <= nxt;
  end

  always_comb begin
    ctl = '0;
    autoReq = REQ_HOLD;
    nxt = state;
    case (state)
      S_IDLE: begin
        ctl.clrRegion = 1'b1;
        nxt = S_SEEK_REQ;
      end
      S_SEEK_REQ: begin
        autoReq = REQ_DEC;
        if (acked) begin
          if (partnerStatus == STS_MIN) begin
            ctl.posClr = 1'b1;
            nxt = S_BASE_REL;
          end else nxt = S_SEEK_REL;
        end
      end
      S_SEEK_REL: if (released) nxt = S_SEEK_REQ;
      S_BASE_REL, S_UP_REL: if (released) begin
        ctl.winClr = 1'b1;
        nxt = S_MEASURE;
      end
      S_MEASURE: begin
        ctl.winRun = 1'b1;
        if (winLast) nxt = S_EVAL;
      end
      S_EVAL: begin
        ctl.record = 1'b1;
        if ((found && !pass) || atMax) nxt = (found || pass) ? S_CENTER : S_FAIL;
        else nxt = S_UP_REQ;
      end
      S_UP_REQ: begin
        autoReq = REQ_INC;
        if (acked) begin
          ctl.posInc = 1'b1;
          ctl.latchMax = 1'b1;
          ctl.maxVal = partnerStatus == STS_MAX;
          nxt = S_UP_REL;
        end
      end
      S_CENTER: nxt = atTarget ? S_DONE : S_BACK_REQ;
      S_BACK_REQ: begin
        autoReq = REQ_DEC;
        if (acked) begin
          ctl.posDec = 1'b1;
          nxt = S_BACK_REL;
        end
      end
      S_BACK_REL: if (released) nxt = S_CENTER;
      S_DONE, S_FAIL: nxt = state;
      default: nxt = S_IDLE;
    endcase
    if (!anDone || manualMode) nxt = S_IDLE;
  end

  assign reqCode   = manualMode ? swReq : autoReq;
  assign trainDone = state == S_DONE;
  assign trainFail = state == S_FAIL;

  // R2: the automatic sequencer never emits the unused code
  assert_req_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    !manualMode |-> reqCode != 2'b11);

  // R1: no request while auto-negotiation is incomplete
  assert_no_train_early_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!anDone) && !manualMode) |-> reqCode == REQ_HOLD);

  // R3: one request never turns into a different one without passing through hold
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!manualMode && !$past(manualMode) && reqCode != REQ_HOLD && $past(reqCode) != REQ_HOLD)
      |-> reqCode == $past(reqCode));

  // R9: completion flags are mutually exclusive
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(trainDone && trainFail));

endmodule

// File: rtl/tap_search_engine.sv
module tap_search_engine
  import tap_search_pkg::*;
#(
  parameter int POS_W = 6,
  parameter int WIN_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             anDone,
  input  logic             manualMode,
  input  logic [1:0]       swReq,
  input  logic [1:0]       partnerStatus,
  input  logic             errEvent,
  input  logic [WIN_W-1:0] winLen,
  input  logic [ERR_W-1:0] errThresh,
  output logic [1:0]       reqCode,
  output logic             trainDone,
  output logic             trainFail
);

  ctl_t ctl;
  logic winLast, pass, found, atMax, atTarget;

  tap_search_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anDone(anDone), .manualMode(manualMode),
    .swReq(swReq), .partnerStatus(partnerStatus), .winLast(winLast),
    .pass(pass), .found(found), .atMax(atMax), .atTarget(atTarget),
    .ctl(ctl), .reqCode(reqCode), .trainDone(trainDone), .trainFail(trainFail)
  );

  tap_search_dp #(.POS_W(POS_W), .WIN_W(WIN_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .errEvent(errEvent),
    .winLen(winLen), .errThresh(errThresh), .winLast(winLast),
    .pass(pass), .found(found), .atMax(atMax), .atTarget(atTarget)
  );

endmodule

// File: tb/tb_tap_search_engine.sv
module tb_tap_search_engine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic anDone = 1'b0;
  logic manualMode = 1'b0;
  logic [1:0] swReq = 2'b00;
  logic [1:0] partnerStatus;
  logic errEvent;
  logic [15:0] winLen = 16'd16;
  logic [7:0] errThresh = 8'd0;
  logic [1:0] reqCode;
  logic trainDone, trainFail;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // partner model state
  int tap;
  int dly;
  logic [1:0] pend;
  logic doLoad = 1'b0;
  int loadVal = 0;
  int gLo = 0, gHi = -1, mLo = 0, mHi = -1;

  // monitors
  int hsViol = 0;
  logic incBeforeMin = 1'b0;
  logic minSeen = 1'b0;
  logic monClr = 1'b0;
  logic [1:0] prevReq = 2'b00;
  logic [1:0] prevStat = 2'b00;

  always #4 clk = ~clk;

  tap_search_engine dut (
    .clk(clk), .rstN(rstN), .anDone(anDone), .manualMode(manualMode),
    .swReq(swReq), .partnerStatus(partnerStatus), .errEvent(errEvent),
    .winLen(winLen), .errThresh(errThresh), .reqCode(reqCode),
    .trainDone(trainDone), .trainFail(trainFail)
  );

  function automatic int quality(int t);
    if (t >= gLo && t <= gHi) return 0;
    if (t >= mLo && t <= mHi) return 1;
    return 2;
  endfunction

  // partner: answers requests two cycles late, releases status after hold
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tap <= 0; dly <= 0; pend <= 2'b00; partnerStatus <= 2'b00; errEvent <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (doLoad) begin
        tap <= loadVal; dly <= 0; partnerStatus <= 2'b00;
      end else if (dly != 0) begin
        if (dly == 1) begin
          if (pend == 2'b01) begin
            if (tap < 15) tap <= tap + 1;
            partnerStatus <= (tap >= 14) ? 2'b11 : 2'b01;
          end else begin
            if (tap > 0) tap <= tap - 1;
            partnerStatus <= (tap <= 1) ? 2'b10 : 2'b01;
          end
        end
        dly <= dly - 1;
      end else if (partnerStatus == 2'b00 && (reqCode == 2'b01 || reqCode == 2'b10)) begin
        dly <= 2; pend <= reqCode;
      end else if (partnerStatus != 2'b00 && reqCode == 2'b00) begin
        partnerStatus <= 2'b00;
      end
      case (quality(tap))
        0: errEvent <= 1'b0;
        1: errEvent <= (cyc % 4) == 0;
        default: errEvent <= 1'b1;
      endcase
    end
  end

  // handshake and ordering monitor (R3, R4)
  always @(negedge clk) begin
    if (monClr) begin
      hsViol <= 0; incBeforeMin <= 1'b0; minSeen <= 1'b0;
    end else if (rstN && !manualMode) begin
      if (prevReq != 2'b00 && reqCode != 2'b00 && reqCode != prevReq) hsViol <= hsViol + 1;
      if (prevReq != 2'b00 && reqCode == 2'b00 && prevStat == 2'b00) hsViol <= hsViol + 1;
      if (prevReq == 2'b00 && reqCode != 2'b00 && prevStat != 2'b00) hsViol <= hsViol + 1;
      if (partnerStatus == 2'b10) minSeen <= 1'b1;
      if (reqCode == 2'b01 && !minSeen) incBeforeMin <= 1'b1;
    end
    prevReq <= reqCode;
    prevStat <= partnerStatus;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(reqCode == 2'b00, "R1 reset reqCode", reqCode, 0);
    chk(!trainDone, "R8 reset trainDone", trainDone, 0);
    chk(!trainFail, "R9 reset trainFail", trainFail, 0);
    repeat (20) @(negedge clk);
    chk(reqCode == 2'b00, "R1 no request before anDone", reqCode, 0);
  endtask

  task automatic run_train(input int initTap, input int lo, input int hi,
                           input int mlo, input int mhi, input int thr, input string name);
    int expLo, expHi, expMid, errs, waited;
    bit expFail;
    @(negedge clk);
    anDone = 1'b0; manualMode = 1'b0;
    gLo = lo; gHi = hi; mLo = mlo; mHi = mhi;
    errThresh = thr[7:0]; loadVal = initTap; doLoad = 1'b1; monClr = 1'b1;
    @(negedge clk);
    doLoad = 1'b0; monClr = 1'b0;
    @(negedge clk);
    anDone = 1'b1;
    expLo = -1; expHi = -1;
    for (int t = 0; t < 16; t++) begin
      errs = (quality(t) == 0) ? 0 : (quality(t) == 1) ? 4 : 16;
      if (errs <= thr) begin
        if (expLo < 0) expLo = t;
        expHi = t;
      end else if (expLo >= 0) break;
    end
    expFail = expLo < 0;
    expMid = (expLo + expHi) / 2;
    waited = 0;
    while (!trainDone && !trainFail && waited < 30000) begin
      @(negedge clk);
      waited++;
    end
    $display("scenario %s: tap=%0d done=%0b fail=%0b", name, tap, trainDone, trainFail);
    if (expFail) begin
      chk(trainFail && !trainDone, "R9 no passing setting gives fail", trainFail, 1);
    end else begin
      chk(trainDone && !trainFail, "R8 done raised", trainDone, 1);
      chk(tap == expMid, "R7 tap at truncated midpoint", tap, expMid);
    end
    chk(hsViol == 0, "R3 request/status handshake", hsViol, 0);
    chk(!incBeforeMin, "R4 descent to minimum first", incBeforeMin, 0);
    repeat (30) @(negedge clk);
    chk(reqCode == 2'b00, "R8 hold after completion", reqCode, 0);
    chk(expFail ? trainFail : trainDone, "R8 flag stays high", expFail ? trainFail : trainDone, 1);
    anDone = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!trainDone && !trainFail, "R1 anDone low clears flags", {trainDone, trainFail}, 0);
  endtask

  task automatic test_manual();
    @(negedge clk);
    manualMode = 1'b1; anDone = 1'b1; swReq = 2'b01;
    @(negedge clk);
    chk(reqCode == 2'b01, "R10 manual increment passes through", reqCode, 1);
    swReq = 2'b10;
    @(negedge clk);
    chk(reqCode == 2'b10, "R10 manual decrement passes through", reqCode, 2);
    swReq = 2'b00;
    repeat (200) @(negedge clk);
    chk(reqCode == 2'b00, "R10 no automatic request in manual", reqCode, 0);
    chk(!trainDone && !trainFail, "R10 no flag in manual", {trainDone, trainFail}, 0);
    manualMode = 1'b0;
    anDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    run_train(6, 3, 8, 0, -1, 0, "mid region R6");
    run_train(0, 10, 15, 0, -1, 0, "region at maximum R6");
    run_train(15, 0, 4, 0, -1, 0, "region at minimum R4");
    run_train(7, 1, 0, 0, -1, 0, "no region R9");
    run_train(2, 4, 6, 7, 9, 4, "marginal counted as pass R5");
    run_train(2, 4, 6, 7, 9, 3, "marginal counted as fail R5");
    test_manual();
    run_train(6, 3, 8, 0, -1, 0, "after manual R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule